// File: doc/BRIEF.md
# Periodic Down-Counting Timer with Output Compare

This block is a 32-bit down counter driven through a small word-addressed register window. It decrements on a prescaled tick from one of three clock-enable inputs. When it reaches zero it either reloads from a programmable period or wraps to all-ones and keeps counting. A compare register is watched continuously. When a counter step lands on the compare value, a sticky status flag is set, and that flag drives a maskable interrupt output.

Software sets the period in the load register and picks a tick source and prescale in the control register, then enables the counter. Two control bits decide how the counter behaves when it is enabled and when the load register is written. An enable can restart the count from a known value or resume from the held count, and a load write can either overwrite the live count at once or only take effect at the next reload. A self-clearing soft-reset bit returns the datapath to its idle state without losing the clock-source and prescale settings.

Top module: `periodic_cmp_timer`

## Requirements
- R1: After a hard reset (rst_n low at a clock edge) control reads 0, status reads 0, load reads 0xFFFFFFFF, compare reads 0, count reads 0 and irq is low.
- R2: Reads at word offsets 0..4 return control, status, load, compare and count. Any other offset reads 0. A write to offset 4 leaves the count unchanged.
- R3: A control write stores bits 25:0 only, so read bits 31:26 are 0. Bit 16 always reads 0.
- R4: A control write with bit 16 set is a soft reset. Control takes the written bits 25:0 with bits 0, 1, 16, 18, 19, 20 and 21 cleared. Status becomes 0, load 0xFFFFFFFF, compare 0, count 0, and the prescaler restarts.
- R5: While control bit 0 (enable) is set, the counter takes one step for every (bits 15:4 + 1) ticks of the selected source. The source is chosen by bits 25:24: 00 gives no ticks, 01 uses src_tick[0], 10 uses src_tick[1], 11 uses src_tick[2]. A step from a non-zero count subtracts one.
- R6: A step from zero reloads the count from the load register when control bit 3 is set, and to 0xFFFFFFFF when it is clear.
- R7: A control write that sets bit 0 while it was clear restarts the prescaler. If the written bit 1 is set, the count becomes the load value (written bit 3 = 1) or 0xFFFFFFFF (bit 3 = 0). If bit 1 is clear, the count resumes from its held value.
- R8: When control bit 17 is set, a load write also sets the count to the written value, and this overrides a step in the same cycle. When bit 17 is clear, a load write leaves the count unchanged.
- R9: With control bit 0 clear, the count holds its value and stays readable.
- R10: Status bit 0 is set when a counter step produces a count equal to the compare value.
- R11: Writing status with bit 0 = 1 clears the flag and writing bit 0 = 0 does nothing. A set in the same cycle wins over the clear.
- R12: irq is high exactly when the status flag is set and control bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| addr | input | 4 | Register word offset |
| wr_en | input | 1 | Write strobe for the register at addr |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for the register at addr |
| src_tick | input | 3 | Tick enables of the three selectable clock sources |
| irq | output | 1 | Compare interrupt |

## Verification
Two collisions are provoked on purpose. In the first, a counter step lands on the compare value in the same cycle that software writes 1 to clear the flag; the flag must read back set and irq must stay high. In the second, a load write with immediate overwrite arrives together with a source tick; the count must show the written value rather than the decremented one. The random phase mixes register writes of all kinds with tick patterns on every source, so both collisions also occur unplanned. Each read and the interrupt level are compared against a cycle model kept in the bench.

// File: rtl/pct_pkg.sv
// Package: shared constants for the periodic compare timer.
// Holds the control field positions, register offsets and the tick-source
// encoding. The field positions are fixed because software decodes them.
package pct_pkg;

    localparam int CTRL_W   = 26;   // stored control width
    localparam int PRE_W    = 12;   // prescaler field width
    localparam int SRC_W    = 2;    // clock-source select width

    // control field positions
    localparam int B_EN     = 0;
    localparam int B_ENMOD  = 1;
    localparam int B_OCIE   = 2;
    localparam int B_RLD    = 3;
    localparam int B_PRE_LO = 4;
    localparam int B_SWR    = 16;
    localparam int B_IOVW   = 17;
    localparam int B_DBG    = 18;
    localparam int B_WAIT   = 19;
    localparam int B_DOZE   = 20;
    localparam int B_STOP   = 21;
    localparam int B_SRC_LO = 24;

    // register word offsets
    localparam int OFS_CTRL = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_LOAD = 2;
    localparam int OFS_CMP  = 3;
    localparam int OFS_CNT  = 4;

    // control bits a soft reset forces low
    localparam logic [CTRL_W-1:0] SOFT_CLR_MASK = CTRL_W'(
        (1 << B_EN) | (1 << B_ENMOD) | (1 << B_SWR) | (1 << B_DBG) |
        (1 << B_WAIT) | (1 << B_DOZE) | (1 << B_STOP));

    typedef enum logic [SRC_W-1:0] {
        SRC_OFF  = 2'b00,
        SRC_PER  = 2'b01,
        SRC_FAST = 2'b10,
        SRC_SLOW = 2'b11
    } clk_src_e;

endpackage

// File: rtl/pct_tick_gen.sv
// Module: pct_tick_gen
// Picks one of N_SRC tick-enable inputs (select 0 means no source) and
// divides it by presc+1. It emits one count-step pulse per division period.
// Assumes the tick inputs are synchronous one-cycle enables on clk.
module pct_tick_gen #(
    parameter int N_SRC = 3,
    parameter int PRE_W = 12,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             run,
    input  logic [PRE_W-1:0] presc,
    input  logic             restart,
    output logic             cnt_tick
);
    logic [N_SRC:0]     tick_vec;
    logic               sel_tick;
    logic               adv;
    logic               wrap;
    logic [PRE_W-1:0]   div_q;

    // entry 0 is the "no clock" source
    assign tick_vec[0] = 1'b0;
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign tick_vec[g+1] = src_tick[g];
    end

    // select the active tick and decide whether this one ends a period
    always_comb begin
        sel_tick = tick_vec[src_sel];
        adv      = run && sel_tick;
        wrap     = adv && (div_q == presc);
    end

    // prescale divider, restarted by soft reset or by an enable edge
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q <= '0;
        end else if (adv) begin
            div_q <= wrap ? '0 : div_q + PRE_W'(1);
        end
    end

    assign cnt_tick = wrap;

endmodule

// File: rtl/pct_down_counter.sv
// Module: pct_down_counter
// Holds the live count. Priority is clear, then parallel load, then step.
// A step from zero reloads from reload_val or wraps to all-ones.
// cmp_hit flags a step whose result equals cmp_val. A load never flags.
module pct_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             step,
    input  logic             reload_mode,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             cmp_hit
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] step_val;

    // value the counter takes on a step
    always_comb begin
        if (count_q == '0) begin
            step_val = reload_mode ? reload_val : '1;
        end else begin
            step_val = count_q - CNT_W'(1);
        end
        cmp_hit = step && !clr && !ld && (step_val == cmp_val);
    end

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count_q <= '0;
        end else if (ld) begin
            count_q <= ld_val;
        end else if (step) begin
            count_q <= step_val;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/pct_regs.sv
// Module: pct_regs
// Register window: control, status flag, load and compare, plus the read
// multiplexer. It decodes soft reset, enable-start loads and immediate
// overwrite loads for the counter. Assumes single-cycle writes and a
// combinational read path.
module pct_regs
    import pct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              cmp_hit,
    output logic [CTRL_W-1:0] ctrl,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              flag,
    output logic              soft_rst,
    output logic              restart,
    output logic              cnt_ld,
    output logic [CNT_W-1:0]  cnt_ld_val,
    output logic [CNT_W-1:0]  rdata
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  load_q;
    logic [CNT_W-1:0]  cmp_q;
    logic              flag_q;
    logic              wr_ctrl, wr_stat, wr_load, wr_cmp;
    logic              en_start, start_ld, ovw_ld;

    // address decode for writes
    always_comb begin
        wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
        wr_stat = wr_en && (addr == ADDR_W'(OFS_STAT));
        wr_load = wr_en && (addr == ADDR_W'(OFS_LOAD));
        wr_cmp  = wr_en && (addr == ADDR_W'(OFS_CMP));
    end

    // side effects of control and load writes on the counter
    always_comb begin
        soft_rst   = wr_ctrl && wdata[B_SWR];
        en_start   = wr_ctrl && !wdata[B_SWR] && wdata[B_EN] && !ctrl_q[B_EN];
        start_ld   = en_start && wdata[B_ENMOD];
        ovw_ld     = wr_load && ctrl_q[B_IOVW];
        restart    = soft_rst || en_start;
        cnt_ld     = start_ld || ovw_ld;
        if (start_ld) begin
            cnt_ld_val = wdata[B_RLD] ? load_q : '1;
        end else begin
            cnt_ld_val = wdata;
        end
    end

    // control register with soft-reset masking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (soft_rst) begin
            ctrl_q <= wdata[CTRL_W-1:0] & ~SOFT_CLR_MASK;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata[CTRL_W-1:0];
        end
    end

    // load and compare registers
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            load_q <= '1;
            cmp_q  <= '0;
        end else begin
            if (wr_load) load_q <= wdata;
            if (wr_cmp)  cmp_q  <= wdata;
        end
    end

    // sticky compare flag, set wins over a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            flag_q <= 1'b0;
        end else if (cmp_hit) begin
            flag_q <= 1'b1;
        end else if (wr_stat && wdata[0]) begin
            flag_q <= 1'b0;
        end
    end

    // read multiplexer, unmapped offsets read zero
    always_comb begin
        unique case (addr)
            ADDR_W'(OFS_CTRL): rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
            ADDR_W'(OFS_STAT): rdata = {{(CNT_W-1){1'b0}}, flag_q};
            ADDR_W'(OFS_LOAD): rdata = load_q;
            ADDR_W'(OFS_CMP):  rdata = cmp_q;
            ADDR_W'(OFS_CNT):  rdata = count;
            default:           rdata = '0;
        endcase
    end

    assign ctrl     = ctrl_q;
    assign load_val = load_q;
    assign cmp_val  = cmp_q;
    assign flag     = flag_q;

endmodule

// File: rtl/periodic_cmp_timer.sv
// Module: periodic_cmp_timer
// Top of the periodic compare timer. Connects the register window, the
// tick selector/prescaler and the down counter, and drives the interrupt
// from the compare flag and its enable. Assumes CNT_W >= 26 so the whole
// control register fits on the data bus.
module periodic_cmp_timer
    import pct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic [2:0]        src_tick,
    output logic              irq
);
    localparam int N_SRC = (1 << SRC_W) - 1;

    logic [CTRL_W-1:0] ctrl;
    logic [CNT_W-1:0]  load_val, cmp_val, count, cnt_ld_val;
    logic              flag, soft_rst, restart, cnt_ld, cmp_hit, cnt_tick;

    pct_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wr_en      (wr_en),
        .wdata      (wdata),
        .count      (count),
        .cmp_hit    (cmp_hit),
        .ctrl       (ctrl),
        .load_val   (load_val),
        .cmp_val    (cmp_val),
        .flag       (flag),
        .soft_rst   (soft_rst),
        .restart    (restart),
        .cnt_ld     (cnt_ld),
        .cnt_ld_val (cnt_ld_val),
        .rdata      (rdata)
    );

    pct_tick_gen #(.N_SRC(N_SRC), .PRE_W(PRE_W), .SEL_W(SRC_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick[N_SRC-1:0]),
        .src_sel  (ctrl[B_SRC_LO +: SRC_W]),
        .run      (ctrl[B_EN]),
        .presc    (ctrl[B_PRE_LO +: PRE_W]),
        .restart  (restart),
        .cnt_tick (cnt_tick)
    );

    pct_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (soft_rst),
        .ld          (cnt_ld),
        .ld_val      (cnt_ld_val),
        .step        (cnt_tick),
        .reload_mode (ctrl[B_RLD]),
        .reload_val  (load_val),
        .cmp_val     (cmp_val),
        .count       (count),
        .cmp_hit     (cmp_hit)
    );

    // interrupt is the flag gated by its enable
    assign irq = flag && ctrl[B_OCIE];

endmodule

// File: rtl/pct_checker.sv
// Module: pct_checker
// Temporal checks on the periodic compare timer, attached by bind.
module pct_checker
    import pct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [CNT_W-1:0]  wdata,
    input logic [CNT_W-1:0]  rdata,
    input logic              irq,
    input logic [CTRL_W-1:0] ctrl,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  load_val,
    input logic              flag,
    input logic              cmp_hit,
    input logic              cnt_tick
);
    // R4
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_CTRL) && wdata[B_SWR]) |=>
        (count == '0 && !flag && load_val == '1 && !ctrl[B_EN] && !ctrl[B_ENMOD]));

    // R9
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[B_EN] && !wr_en) |=> $stable(count));

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !wr_en && count != '0) |=> (count == $past(count) - CNT_W'(1)));

    // R6
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !wr_en && count == '0 && ctrl[B_RLD]) |=> (count == $past(load_val)));

    // R6
    reload_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !wr_en && count == '0 && !ctrl[B_RLD]) |=> (count == '1));

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |=> flag);

    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_STAT) && wdata[0] && !cmp_hit) |=> !flag);

    // R12
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> flag);

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > ADDR_W'(OFS_CNT)) |-> (rdata == '0));

endmodule

bind periodic_cmp_timer pct_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq      (irq),
    .ctrl     (ctrl),
    .count    (count),
    .load_val (load_val),
    .flag     (flag),
    .cmp_hit  (cmp_hit),
    .cnt_tick (cnt_tick)
);

// File: tb/tb_periodic_cmp_timer.sv
// Bench for periodic_cmp_timer: directed corner cases plus seeded random
// traffic, compared against a cycle model kept in bench tasks.
module tb_periodic_cmp_timer;

    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [2:0]  src_tick = '0;
    logic [31:0] rdata;
    logic        irq;

    int vectors = 0;
    int errors  = 0;

    // model state
    logic [25:0] m_ctrl;
    logic        m_flag;
    logic [31:0] m_load, m_cmp, m_cnt;
    logic [11:0] m_ps;

    always #4 clk = ~clk;

    periodic_cmp_timer #(.CNT_W(32), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .src_tick(src_tick), .irq(irq)
    );

    task automatic model_reset();
        m_ctrl = '0; m_flag = 1'b0; m_load = '1; m_cmp = '0; m_cnt = '0; m_ps = '0;
    endtask

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        case (a)
            4'd0: return {6'b0, m_ctrl};
            4'd1: return {31'b0, m_flag};
            4'd2: return m_load;
            4'd3: return m_cmp;
            4'd4: return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    // one clock of the model, from the requirements
    task automatic model_step(input logic [AW-1:0] a, input logic w,
                              input logic [31:0] d, input logic [2:0] t);
        logic [25:0] c;
        logic [1:0]  src;
        logic        sel, adv, ctk, hit, ld;
        logic [31:0] old_load, old_cmp, nxt;
        c = m_ctrl; src = c[25:24];
        sel = (src != 2'd0) && t[src - 2'd1];
        adv = c[0] && sel;
        ctk = adv && (m_ps == c[15:4]);
        old_load = m_load; old_cmp = m_cmp;
        hit = 1'b0; ld = 1'b0;
        if (adv) m_ps = ctk ? 12'd0 : m_ps + 12'd1;
        if (w && a == 4'd0 && d[16]) begin
            m_ctrl = d[25:0] & ~26'h03D0003;
            m_flag = 1'b0; m_load = '1; m_cmp = '0; m_cnt = '0; m_ps = '0;
            return;
        end
        if (w && a == 4'd0) begin
            if (d[0] && !c[0]) begin
                m_ps = '0;
                if (d[1]) begin m_cnt = d[3] ? old_load : '1; ld = 1'b1; end
            end
            m_ctrl = d[25:0];
        end
        if (w && a == 4'd2) begin
            m_load = d;
            if (c[17]) begin m_cnt = d; ld = 1'b1; end
        end
        if (w && a == 4'd3) m_cmp = d;
        if (!ld && ctk) begin
            nxt = (m_cnt == 0) ? (c[3] ? old_load : 32'hFFFF_FFFF) : m_cnt - 32'd1;
            m_cnt = nxt;
            hit = (nxt == old_cmp);
        end
        if (w && a == 4'd1 && d[0]) m_flag = 1'b0;
        if (hit) m_flag = 1'b1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock with the given inputs, model updated at the edge
    task automatic cyc(input logic [AW-1:0] a, input logic w,
                       input logic [31:0] d, input logic [2:0] t);
        @(negedge clk);
        addr = a; wr_en = w; wdata = d; src_tick = t;
        @(posedge clk);
        model_step(a, w, d, t);
    endtask

    // idle half-cycle probe of one register and of irq
    task automatic probe(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        addr = a; wr_en = 1'b0; src_tick = '0;
        #1;
        check(tag, rdata, exp_read(a));
        check({tag, " irq"}, {31'b0, irq}, {31'b0, m_flag & m_ctrl[2]});
    endtask

    task automatic ticks(input int n, input logic [2:0] t);
        for (int i = 0; i < n; i++) cyc(4'd0, 1'b0, 32'h0, t);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) probe(AW'(a), "R1 reset");

        // R3 control width, bit 16 reads zero
        cyc(4'd0, 1'b1, 32'hFFFE_FFF0, 3'b000);
        probe(4'd0, "R3 ctrl width");

        // R2 map, count read-only, unmapped zero
        cyc(4'd4, 1'b1, 32'h0000_1234, 3'b000);
        probe(4'd4, "R2 count read-only");
        cyc(4'd2, 1'b1, 32'd5, 3'b000);
        probe(4'd2, "R2 load");
        cyc(4'd3, 1'b1, 32'd7, 3'b000);
        probe(4'd3, "R2 compare");
        probe(4'd5, "R2 unmapped");
        probe(4'd15, "R2 unmapped");

        // R4 soft reset keeps only the allowed control bits
        cyc(4'd0, 1'b1, 32'h03FF_FFFF, 3'b000);
        for (int a = 0; a < 5; a++) probe(AW'(a), "R4 soft reset");

        // R7 enable start from load, R5 prescale by 3 on source 01
        cyc(4'd2, 1'b1, 32'd10, 3'b000);
        cyc(4'd0, 1'b1, 32'h0100_002B, 3'b000);
        probe(4'd4, "R7 start from load");
        ticks(3, 3'b001);
        probe(4'd4, "R5 one step per 3 ticks");
        ticks(6, 3'b110);
        probe(4'd4, "R5 unselected sources ignored");

        // R6 reload from load register
        ticks(30, 3'b001);
        probe(4'd4, "R6 reload from load");
        // R6 free-running wrap
        cyc(4'd0, 1'b1, 32'h0100_0023, 3'b000);
        ticks(33, 3'b001);
        probe(4'd4, "R6 wrap to all-ones");

        // R9 disable freezes
        cyc(4'd0, 1'b1, 32'h0100_0022, 3'b000);
        ticks(9, 3'b111);
        probe(4'd4, "R9 frozen while disabled");

        // R7 resume from held value, then R5 step with prescale 0
        cyc(4'd0, 1'b1, 32'h0100_0001, 3'b000);
        probe(4'd4, "R7 resume held count");
        ticks(1, 3'b001);
        probe(4'd4, "R5 step prescale 0");

        // R8 immediate overwrite beats a same-cycle step
        cyc(4'd0, 1'b1, 32'h0102_0001, 3'b000);
        cyc(4'd2, 1'b1, 32'd100, 3'b001);
        probe(4'd4, "R8 overwrite over tick");
        cyc(4'd0, 1'b1, 32'h0100_0001, 3'b000);
        cyc(4'd2, 1'b1, 32'd50, 3'b000);
        probe(4'd4, "R8 deferred load");

        // R10, R12 compare hit raises flag and irq
        cyc(4'd0, 1'b1, 32'h0100_0005, 3'b000);
        cyc(4'd3, 1'b1, 32'd97, 3'b000);
        ticks(3, 3'b001);
        probe(4'd1, "R10 compare flag");
        // R11 write 0 ignored, write 1 clears
        cyc(4'd1, 1'b1, 32'h0000_0000, 3'b000);
        probe(4'd1, "R11 write zero ignored");
        cyc(4'd1, 1'b1, 32'h0000_0001, 3'b000);
        probe(4'd1, "R11 clear");
        // R11 set wins over same-cycle clear
        cyc(4'd3, 1'b1, 32'd95, 3'b000);
        ticks(1, 3'b001);
        cyc(4'd1, 1'b1, 32'h0000_0001, 3'b001);
        probe(4'd1, "R11 set wins");
        // R12 mask
        cyc(4'd0, 1'b1, 32'h0100_0001, 3'b000);
        probe(4'd1, "R12 irq masked");
        // R5 source 00 gives no ticks
        cyc(4'd0, 1'b1, 32'h0000_0001, 3'b000);
        ticks(5, 3'b111);
        probe(4'd4, "R5 no-clock source");

        // seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            logic [31:0] d;
            logic [2:0]  t;
            r = $urandom % 16;
            t = 3'($urandom);
            d = $urandom;
            if (r < 9) begin
                cyc(4'd0, 1'b0, 32'h0, t);
            end else if (r == 9) begin
                d = d & 32'h03FF_FFFF;
                d[15:4] = 12'($urandom % 3);
                d[16] = (($urandom % 20) == 0);
                cyc(4'd0, 1'b1, d, t);
            end else if (r == 10) begin
                cyc(4'd1, 1'b1, d, t);
            end else if (r <= 12) begin
                cyc(4'd2, 1'b1, 32'($urandom % 40), t);
            end else if (r == 13) begin
                cyc(4'd3, 1'b1, 32'($urandom % 40), t);
            end else if (r == 14) begin
                cyc(AW'(4 + $urandom % 12), 1'b1, d, t);
            end else begin
                cyc(4'd0, 1'b0, 32'h0, 3'b111);
            end
            probe(AW'($urandom % 8), "R2 random read");
            if (n % 4 == 0) probe(4'd4, "R5 random count");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule